// File: doc/BRIEF.md
# Programmable Transmit Clock-Enable Generator

This block produces the timing enables for a transmit data path. Everything runs in one fast system-clock domain, and that clock runs at the DAC sample rate. The block does not make new clocks. It emits single-cycle strobes that downstream logic uses as clock enables:

- a DAC sample strobe;
- a reference-rate strobe that fires once every L system cycles;
- a strobe for the input port that accepts half-words;
- a master-clock strobe at one quarter of the system rate;
- an auxiliary reference-output strobe.

Four configuration fields set the divide ratios: the multiplier L, the interpolation factor K, the port multiplexer mode and the auxiliary divider R. All dividers restart in phase whenever any of these fields changes. A combination that would need the port to run faster than the DAC raises an error flag.

Top module: `tx_clken_gen`

## Requirements
- R1: While `rst` is high every strobe and `cfg_err` are low. The first cycle after `rst` falls is phase index n=0 of every divider.
- R2: Out of reset, `dac_stb` is high in every cycle.
- R3: `osc_stb` is high once every L cycles, at n = L-1, 2L-1 and so on. The field `mult_sel` encodes L as 0→1, 1→2, 2→3 and 3→8.
- R4: With `mux_on` low, `port_stb` fires once every K cycles, at n = K-1 (mod K). The field `interp_sel` encodes K as 0→1, 1→2 and 2→4.
- R5: With `mux_on` high, the port period is K/2, with a minimum of 1 cycle. So K=1 and K=2 both give a strobe every cycle, and K=4 gives one every 2 cycles.
- R6: `mclk_stb` is high at n = 3, 7, 11 and so on (once every 4 cycles).
- R7: When `ref_div` is 2 or 3, `ref_stb` fires once every 4·R cycles, at n = 4R-1 (mod 4R). It therefore always coincides with an `mclk_stb` pulse.
- R8: When `ref_div` is 0 (the default) or 1 (reserved), `ref_stb` is identical to `osc_stb`.
- R9: `cfg_err` is high exactly when `mux_on` is high with `interp_sel`=0, or when `interp_sel`=3. Code 3 is reserved and divides like K=4.
- R10: If any configuration field differs from the value captured at the previous clock edge, the cycle after that edge is n=0 for every divider. The cycle in which the change is first seen still follows the old configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at DAC rate |
| rst | input | 1 | Synchronous active-high reset |
| mult_sel | input | 2 | Multiplier L code |
| interp_sel | input | 2 | Interpolation K code |
| mux_on | input | 1 | Port multiplexer mode (doubles port rate) |
| ref_div | input | 2 | Auxiliary divider R |
| dac_stb | output | 1 | DAC sample enable |
| osc_stb | output | 1 | Reference-rate enable (1 in L) |
| port_stb | output | 1 | Input port half-word enable |
| mclk_stb | output | 1 | Master-clock enable (1 in 4) |
| ref_stb | output | 1 | Auxiliary reference-output enable |
| cfg_err | output | 1 | Invalid configuration flag |

## Verification
Some properties hold on every cycle, and the assertions check these continuously:

- the DAC strobe is never absent out of reset;
- the master-clock strobe never fires on two cycles in a row;
- a divided reference strobe always lands on a master-clock strobe;
- with a low R, the reference strobe mirrors the L strobe;
- with L=1, the L strobe stays high;
- the error flag matches the decoded fields.

Other behaviour depends on exact phase, and only the bench scenarios show it. This covers the exact cycle of each pulse after a restart from an arbitrary phase, the period for every combination of L, K, mux and R, and the property that a change of one field moves every divider back to phase zero.

// File: rtl/txce_pkg.sv
package txce_pkg;

    localparam int SEL_W   = 2;
    localparam int STB_N   = 5;
    localparam int IDX_DAC  = 0;
    localparam int IDX_OSC  = 1;
    localparam int IDX_PORT = 2;
    localparam int IDX_MCLK = 3;
    localparam int IDX_REF  = 4;
    localparam int L_MAX   = 8;

    typedef struct packed {
        logic [SEL_W-1:0] mult;
        logic [SEL_W-1:0] interp;
        logic             mux;
        logic [SEL_W-1:0] rdiv;
    } txce_cfg_t;

    function automatic int mult_factor(input logic [SEL_W-1:0] code);
        case (code)
            2'd0:    return 1;
            2'd1:    return 2;
            2'd2:    return 3;
            default: return 8;
        endcase
    endfunction

    function automatic int interp_factor(input logic [SEL_W-1:0] code);
        case (code)
            2'd0:    return 1;
            2'd1:    return 2;
            default: return 4;
        endcase
    endfunction

    function automatic int port_period(input txce_cfg_t c);
        int k;
        k = interp_factor(c.interp);
        if (c.mux) return (k < 2) ? 1 : k / 2;
        return k;
    endfunction

    function automatic int ref_period(input txce_cfg_t c, input int mclk_div);
        if (c.rdiv >= 2'd2) return mclk_div * int'(c.rdiv);
        return mult_factor(c.mult);
    endfunction

    function automatic logic cfg_invalid(input txce_cfg_t c);
        return (c.interp == 2'd3) || (c.mux && (c.interp == 2'd0));
    endfunction

endpackage

// File: rtl/txce_div.sv
module txce_div #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic [W-1:0] period,
    output logic         strobe
);
    logic [W-1:0] cnt;
    logic         last;

    assign last   = (cnt == period - 1'b1);
    assign strobe = last;

    always_ff @(posedge clk) begin
        if (rst || restart) cnt <= '0;
        else if (last)      cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/txce_cfg.sv
module txce_cfg
    import txce_pkg::*;
#(
    parameter int CNT_W    = 4,
    parameter int MCLK_DIV = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  txce_cfg_t                   cfg_in,
    output logic                        restart,
    output logic [STB_N-1:0][CNT_W-1:0] period,
    output logic                        bad
);
    txce_cfg_t cfg_q;

    // captured every edge; a difference means the fields moved
    always_ff @(posedge clk) cfg_q <= cfg_in;

    assign restart = rst ? 1'b0 : (cfg_in != cfg_q);

    always_comb begin
        period[IDX_DAC]  = CNT_W'(1);
        period[IDX_OSC]  = CNT_W'(mult_factor(cfg_q.mult));
        period[IDX_PORT] = CNT_W'(port_period(cfg_q));
        period[IDX_MCLK] = CNT_W'(MCLK_DIV);
        period[IDX_REF]  = CNT_W'(ref_period(cfg_q, MCLK_DIV));
        bad              = cfg_invalid(cfg_q);
    end
endmodule

// File: rtl/tx_clken_gen.sv
module tx_clken_gen
    import txce_pkg::*;
#(
    parameter int MCLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mult_sel,
    input  logic [1:0] interp_sel,
    input  logic       mux_on,
    input  logic [1:0] ref_div,
    output logic       dac_stb,
    output logic       osc_stb,
    output logic       port_stb,
    output logic       mclk_stb,
    output logic       ref_stb,
    output logic       cfg_err
);
    localparam int MAX_P = (MCLK_DIV * 3 > L_MAX) ? MCLK_DIV * 3 : L_MAX;
    localparam int CNT_W = $clog2(MAX_P + 1);

    txce_cfg_t                   cfg_in;
    logic                        restart;
    logic                        bad;
    logic [STB_N-1:0][CNT_W-1:0] period;
    logic [STB_N-1:0]            stb_raw;

    assign cfg_in = '{mult: mult_sel, interp: interp_sel, mux: mux_on, rdiv: ref_div};

    txce_cfg #(.CNT_W(CNT_W), .MCLK_DIV(MCLK_DIV)) u_cfg (
        .clk(clk), .rst(rst), .cfg_in(cfg_in),
        .restart(restart), .period(period), .bad(bad)
    );

    for (genvar g = 0; g < STB_N; g++) begin : g_div
        txce_div #(.W(CNT_W)) u_div (
            .clk(clk), .rst(rst), .restart(restart),
            .period(period[g]), .strobe(stb_raw[g])
        );
    end

    assign dac_stb  = stb_raw[IDX_DAC]  & ~rst;
    assign osc_stb  = stb_raw[IDX_OSC]  & ~rst;
    assign port_stb = stb_raw[IDX_PORT] & ~rst;
    assign mclk_stb = stb_raw[IDX_MCLK] & ~rst;
    assign ref_stb  = stb_raw[IDX_REF]  & ~rst;
    assign cfg_err  = bad & ~rst;
endmodule

// File: rtl/txce_chk.sv
module txce_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mult_sel,
    input logic [1:0] interp_sel,
    input logic       mux_on,
    input logic [1:0] ref_div,
    input logic       dac_stb,
    input logic       osc_stb,
    input logic       port_stb,
    input logic       mclk_stb,
    input logic       ref_stb,
    input logic       cfg_err
);
    logic [6:0] fields;
    assign fields = {mult_sel, interp_sel, mux_on, ref_div};

    // R1
    always @(posedge clk)
        if (rst) reset_quiet_chk: assert ({dac_stb, osc_stb, port_stb, mclk_stb, ref_stb, cfg_err} == 6'b0);

    // R2
    dac_every_cycle_chk: assert property (@(posedge clk) disable iff (rst) dac_stb);

    // R3
    osc_unity_chk: assert property (@(posedge clk) disable iff (rst)
        ($stable(fields) && mult_sel == 2'd0) |-> osc_stb);

    // R6
    mclk_gap_chk: assert property (@(posedge clk) disable iff (rst) mclk_stb |=> !mclk_stb);

    // R7
    ref_on_mclk_chk: assert property (@(posedge clk) disable iff (rst)
        ($stable(fields) && ref_div[1] && ref_stb) |-> mclk_stb);

    // R8
    ref_follows_osc_chk: assert property (@(posedge clk) disable iff (rst)
        ($stable(fields) && !ref_div[1]) |-> (ref_stb == osc_stb));

    // R9
    err_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $stable(fields) |-> (cfg_err == ((interp_sel == 2'd3) || (mux_on && interp_sel == 2'd0))));
endmodule

bind tx_clken_gen txce_chk u_chk (
    .clk(clk), .rst(rst), .mult_sel(mult_sel), .interp_sel(interp_sel),
    .mux_on(mux_on), .ref_div(ref_div), .dac_stb(dac_stb), .osc_stb(osc_stb),
    .port_stb(port_stb), .mclk_stb(mclk_stb), .ref_stb(ref_stb), .cfg_err(cfg_err)
);

// File: tb/sim_tx_clken_gen.sv
module sim_tx_clken_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mult_sel = 2'd3, interp_sel = 2'd2, ref_div = 2'd3;
    logic       mux_on = 1'b1;
    logic dac_stb, osc_stb, port_stb, mclk_stb, ref_stb, cfg_err;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tx_clken_gen u0 (.*);

    function automatic int lval(input logic [1:0] c);
        return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : (c == 2'd2) ? 3 : 8;
    endfunction
    function automatic int kval(input logic [1:0] c);
        return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b (L=%0d K=%0d mux=%0b R=%0d)",
                     tag, act, exp, mult_sel, interp_sel, mux_on, ref_div);
        end
    endtask

    task automatic check_all(input int n);
        int pl, pp, pr;
        pl = lval(mult_sel);
        pp = mux_on ? ((kval(interp_sel) < 2) ? 1 : kval(interp_sel) / 2) : kval(interp_sel);
        pr = (ref_div >= 2) ? 4 * int'(ref_div) : pl;
        chk("R2", dac_stb, 1'b1);
        chk("R3", osc_stb, (n % pl) == pl - 1);
        chk(mux_on ? "R5" : "R4", port_stb, (n % pp) == pp - 1);
        chk("R6", mclk_stb, (n % 4) == 3);
        chk((ref_div >= 2) ? "R7" : "R8", ref_stb, (n % pr) == pr - 1);
        chk("R9", cfg_err, (interp_sel == 2'd3) || (mux_on && interp_sel == 2'd0));
    endtask

    task automatic run_window(input int ncyc, input bit first_now);
        for (int n = 0; n < ncyc; n++) begin
            if (n > 0 || !first_now) begin
                @(negedge clk); #1;
            end
            check_all(n);
        end
    endtask

    task automatic set_cfg(input logic [1:0] m, input logic [1:0] k, input logic x, input logic [1:0] r);
        mult_sel = m; interp_sel = k; mux_on = x; ref_div = r;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        // R1: outputs quiet during reset
        repeat (3) begin
            @(negedge clk); #1;
            chk("R1", |{dac_stb, osc_stb, port_stb, mclk_stb, ref_stb, cfg_err}, 1'b0);
        end
        rst = 1'b0; #1;
        run_window(24, 1'b1);   // R1: phase zero right after release

        // sweep of every configuration, each entered from the previous phase
        for (int m = 0; m < 4; m++)
            for (int k = 0; k < 4; k++)
                for (int x = 0; x < 2; x++)
                    for (int r = 0; r < 4; r++) begin
                        set_cfg(2'(m), 2'(k), 1'(x), 2'(r));
                        run_window(24, 1'b0);
                    end

        // R10: change only R mid-phase; all dividers realign
        set_cfg(2'd1, 2'd1, 1'b0, 2'd2);
        run_window(5, 1'b0);
        set_cfg(2'd1, 2'd1, 1'b0, 2'd3);
        for (int n = 0; n < 12; n++) begin
            @(negedge clk); #1;
            chk("R10", mclk_stb, (n % 4) == 3);
            chk("R10", osc_stb, (n % 2) == 1);
            chk("R10", ref_stb, n == 11);
        end
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end
endmodule